// File: doc/BRIEF.md
# Phase-Shift Full-Bridge PWM Generator

This block drives the four primary switches of a full bridge at a fixed switching frequency. The leading leg (A) runs at a fixed phase, and the lagging leg (B) follows it with a delay equal to the effective on-time. The transformer therefore sees a positive pulse, then a negative pulse of equal width in every period. The on-time comes from a digital duty command. It is never allowed below a programmed floor, which keeps enough stored energy for soft switching at light load.

The gap between turning off one switch of a leg and turning on its partner (the dead time) is taken from a four-entry table. A load band selects the entry. The band comes from a digitized current-sense code compared against three thresholds, with a hysteresis margin on the way down. When the duty command is below the floor, a mode manager may request pulse skipping. Whole periods are then suppressed instead of producing narrower pulses. A peak-current input cuts the leading leg off for the rest of the current half-period. Duty, floor, dead time and skip decisions are taken only at a period boundary.

Top module: `psfb_pwm`

## Requirements
- R1: The switching period is fixed at 2*HALF_TICKS clock cycles (64 by default). Successive falling edges of `gate_a_lo` are exactly one period apart.
- R2: The effective on-time is max(`duty_cmd`, `min_on`), limited to HALF_TICKS. `gate_b_lo` falls exactly that many cycles after `gate_a_lo` falls.
- R3: In a driven period each of `gate_a_hi` and `gate_b_hi` is high for HALF_TICKS minus dt cycles. Here dt is the dead-time entry of the current load band.
- R4: The load band runs from 0 (lightest load) to 3, and band b uses the dead time `dt_table[8*b +: 8]`. Threshold i is `band_thr[10*i +: 10]`. Each clock, the band rises by one step when `cs_code` >= threshold[band]. Otherwise it falls by one step when `cs_code` < threshold[band-1] - `band_hyst`.
- R5: When `duty_cmd` is below `min_on` and skipping is not requested, pulses are held at `min_on` wide and are not narrowed.
- R6: A period is skipped when `skip_req` is high and `duty_cmd` < `min_on` at its start. In a skipped period all four gates stay low for the whole period. `skip_req` has no effect when `duty_cmd` >= `min_on`.
- R7: Each driven period contains one positive interval (`gate_a_hi` and `gate_b_lo`) and one negative interval (`gate_a_lo` and `gate_b_hi`). Both intervals are on-time minus dt cycles long, so the transformer polarity alternates.
- R8: A high `ilim` sampled at a clock edge forces both leading-leg gates low from that edge until the end of the current half-period. The other half-period is unaffected.
- R9: Changes to `duty_cmd`, `min_on`, `skip_req` and the band take effect only at the start of the next period.
- R10: `rst_n` is a synchronous active-low reset. The gates are low at the first edge with reset low. After release they stay low for the whole first period.
- R11: The two gates of one leg are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_cmd | input | SH_W (6) | Demanded on-time in ticks |
| min_on | input | SH_W (6) | Minimum on-time floor in ticks |
| cs_code | input | CS_W (10) | Digitized primary current-sense value |
| band_thr | input | (NBAND-1)*CS_W (30) | Three rising band thresholds, threshold i at bits [10*i +: 10] |
| band_hyst | input | CS_W (10) | Margin subtracted from a threshold when falling a band |
| dt_table | input | NBAND*DT_W (32) | Dead time per band in ticks, band b at bits [8*b +: 8] |
| skip_req | input | 1 | Pulse-skip request from the mode manager |
| ilim | input | 1 | Peak-current comparator output |
| gate_a_hi | output | 1 | Leading leg, high-side switch |
| gate_a_lo | output | 1 | Leading leg, low-side switch |
| gate_b_hi | output | 1 | Lagging leg, high-side switch |
| gate_b_lo | output | 1 | Lagging leg, low-side switch |

## Verification
Each gate is registered once from the period counter, so a gate reflects the counter value of the previous clock. Edge-to-edge distances between gates therefore equal the programmed tick counts exactly.

- A new duty, floor or skip setting, or a new band, appears only in the period after the next boundary. The bench waits three full periods after every stimulus change before it measures one period, starting at a falling edge of `gate_a_lo`.
- An `ilim` pulse acts at the very next edge. A reset takes effect one edge after `rst_n` falls. The bench samples both on the following falling clock edge.
- The mid-period duty change is checked on the period in progress (old value) and then on the next period (new value).

// File: rtl/psfb_pkg.sv
`timescale 1ns/1ps
package psfb_pkg;

  // Effective phase shift: floor the demand, then limit it to one half-period.
  function automatic int shift_of(int demand, int floor_v, int half);
    int s;
    s = (demand < floor_v) ? floor_v : demand;
    if (s > half) s = half;
    return s;
  endfunction

  // Position of a leg inside the period once it is delayed by lag ticks.
  function automatic int lag_phase(int cnt, int lag, int period);
    return (cnt + period - lag) % period;
  endfunction

  // Subtraction that stops at zero.
  function automatic int sat_sub(int a, int b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/psfb_leg.sv
`timescale 1ns/1ps
module psfb_leg #(
  parameter int CNT_W = 6,
  parameter int DT_W  = 8,
  parameter int HALF  = 32
) (
  input  logic [CNT_W-1:0] phase,
  input  logic [DT_W-1:0]  dt,
  output logic             drv_hi,
  output logic             drv_lo
);
  int ph;
  int gap;

  always_comb begin
    ph     = int'(phase);
    gap    = int'(dt);
    // High side: first half of the leg's phase, delayed by the dead time.
    drv_hi = (ph >= gap) && (ph < HALF);
    // Low side: second half of the leg's phase, delayed by the dead time.
    drv_lo = (ph >= HALF + gap);
  end
endmodule

// File: rtl/psfb_band_sel.sv
`timescale 1ns/1ps
module psfb_band_sel
  import psfb_pkg::*;
#(
  parameter int CS_W   = 10,
  parameter int NBAND  = 4,
  parameter int BAND_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CS_W-1:0]             cs_code,
  input  logic [(NBAND-1)*CS_W-1:0]   band_thr,
  input  logic [CS_W-1:0]             band_hyst,
  output logic [BAND_W-1:0]           band
);
  logic [CS_W-1:0] thr_a [NBAND];
  logic [CS_W-1:0] fall_lvl;
  logic            step_up;
  logic            step_dn;

  for (genvar i = 0; i < NBAND - 1; i++) begin : g_thr
    assign thr_a[i] = band_thr[i*CS_W +: CS_W];
  end
  // The top band has nothing above it.
  assign thr_a[NBAND-1] = '1;

  always_comb begin
    fall_lvl = CS_W'(sat_sub(int'(thr_a[band - 1'b1]), int'(band_hyst)));
    step_up  = (band != BAND_W'(NBAND - 1)) && (cs_code >= thr_a[band]);
    step_dn  = (band != '0) && (cs_code < fall_lvl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       band <= '0;
    else if (step_up) band <= band + 1'b1;
    else if (step_dn) band <= band - 1'b1;
  end

  AST_BAND_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (band != $past(band)) |->
      (band == $past(band) + 1'b1) || (band == $past(band) - 1'b1)); // R4
endmodule

// File: rtl/psfb_pwm.sv
`timescale 1ns/1ps
module psfb_pwm
  import psfb_pkg::*;
#(
  parameter int HALF_TICKS = 32,
  parameter int CS_W       = 10,
  parameter int DT_W       = 8,
  parameter int NBAND      = 4,
  localparam int PERIOD    = 2 * HALF_TICKS,
  localparam int CNT_W     = $clog2(PERIOD),
  localparam int SH_W      = $clog2(HALF_TICKS + 1),
  localparam int BAND_W    = $clog2(NBAND)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SH_W-1:0]            duty_cmd,
  input  logic [SH_W-1:0]            min_on,
  input  logic [CS_W-1:0]            cs_code,
  input  logic [(NBAND-1)*CS_W-1:0]  band_thr,
  input  logic [CS_W-1:0]            band_hyst,
  input  logic [NBAND*DT_W-1:0]      dt_table,
  input  logic                       skip_req,
  input  logic                       ilim,
  output logic                       gate_a_hi,
  output logic                       gate_a_lo,
  output logic                       gate_b_hi,
  output logic                       gate_b_lo
);
  // Period timebase and settings that are held for one period.
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  logic              skip_q;
  logic              trunc_q;
  logic [SH_W-1:0]   on_q;
  logic [SH_W-1:0]   floor_q;
  logic [DT_W-1:0]   dt_q;
  logic [BAND_W-1:0] band;

  // Named internal events.
  logic              period_end;
  logic              half_end;
  logic              skip_next;
  logic              drive_en;
  logic              cut_now;
  logic [SH_W-1:0]   shift_next;
  logic [DT_W-1:0]   dt_sel;
  logic [1:0]        leg_hi;
  logic [1:0]        leg_lo;

  assign period_end = (cnt_q == CNT_W'(PERIOD - 1));
  assign half_end   = (cnt_q == CNT_W'(HALF_TICKS - 1));
  assign skip_next  = skip_req && (duty_cmd < min_on);
  assign shift_next = SH_W'(shift_of(int'(duty_cmd), int'(min_on), HALF_TICKS));
  assign dt_sel     = dt_table[int'(band)*DT_W +: DT_W];
  assign drive_en   = run_q && !skip_q;
  assign cut_now    = ilim || trunc_q;

  psfb_band_sel #(
    .CS_W   (CS_W),
    .NBAND  (NBAND),
    .BAND_W (BAND_W)
  ) u_band (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_code   (cs_code),
    .band_thr  (band_thr),
    .band_hyst (band_hyst),
    .band      (band)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (period_end) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // Period-boundary latch: nothing changes inside a period.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      skip_q  <= 1'b0;
      on_q    <= '0;
      floor_q <= '0;
      dt_q    <= '0;
    end else if (period_end) begin
      run_q   <= 1'b1;
      skip_q  <= skip_next;
      on_q    <= shift_next;
      floor_q <= min_on;
      dt_q    <= dt_sel;
    end
  end

  // Peak-current cut holds to the end of the half-period it hit.
  always_ff @(posedge clk) begin
    if (!rst_n)                     trunc_q <= 1'b0;
    else if (half_end || period_end) trunc_q <= 1'b0;
    else                            trunc_q <= trunc_q || ilim;
  end

  // Leg 0 leads with no lag, leg 1 lags by the effective on-time.
  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic [CNT_W-1:0] ph;
    assign ph = CNT_W'(lag_phase(int'(cnt_q), (g == 0) ? 0 : int'(on_q), PERIOD));
    psfb_leg #(
      .CNT_W (CNT_W),
      .DT_W  (DT_W),
      .HALF  (HALF_TICKS)
    ) u_leg (
      .phase  (ph),
      .dt     (dt_q),
      .drv_hi (leg_hi[g]),
      .drv_lo (leg_lo[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_a_hi <= 1'b0;
      gate_a_lo <= 1'b0;
      gate_b_hi <= 1'b0;
      gate_b_lo <= 1'b0;
    end else begin
      gate_a_hi <= drive_en && leg_hi[0] && !cut_now;
      gate_a_lo <= drive_en && leg_lo[0] && !cut_now;
      gate_b_hi <= drive_en && leg_hi[1];
      gate_b_lo <= drive_en && leg_lo[1];
    end
  end

  AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a_hi && gate_a_lo) && !(gate_b_hi && gate_b_lo)); // R11

  AST_DARK_FIRST_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo)); // R10

  AST_ILIM_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    ilim |=> !gate_a_hi && !gate_a_lo); // R8

  AST_SKIP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |=> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo)); // R6

  AST_ON_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !skip_q && (int'(floor_q) <= HALF_TICKS)) |-> (on_q >= floor_q)); // R5
endmodule

// File: tb/psfb_pwm_tb.sv
`timescale 1ns/1ps
module psfb_pwm_tb;
  localparam int HALF = 32;
  localparam int P    = 2 * HALF;
  localparam int NV   = 7;

  // Stimulus and expected results, one column per vector.
  localparam int V_DUTY [NV] = '{20, 10,  3,  20,  15,  12,  30};
  localparam int V_MIN  [NV] = '{ 5,  5,  8,   5,   5,   5,   5};
  localparam int V_CS   [NV] = '{100, 300, 700, 590, 500, 395, 100};
  localparam int E_ON   [NV] = '{20, 10,  8,  20,  15,  12,  30};
  localparam int E_DT   [NV] = '{ 2,  4,  8,   8,   6,   6,   2};

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] duty_cmd;
  logic [5:0] min_on;
  logic [9:0] cs_code;
  logic [29:0] band_thr;
  logic [9:0] band_hyst;
  logic [31:0] dt_table;
  logic       skip_req;
  logic       ilim;
  logic       a_hi, a_lo, b_hi, b_lo;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  psfb_pwm u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .duty_cmd  (duty_cmd),
    .min_on    (min_on),
    .cs_code   (cs_code),
    .band_thr  (band_thr),
    .band_hyst (band_hyst),
    .dt_table  (dt_table),
    .skip_req  (skip_req),
    .ilim      (ilim),
    .gate_a_hi (a_hi),
    .gate_a_lo (a_lo),
    .gate_b_hi (b_hi),
    .gate_b_lo (b_lo)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Returns at the falling clock edge where gate_a_lo is first seen low.
  task automatic wait_start();
    logic pa;
    int guard;
    guard = 0;
    do begin
      pa = a_lo;
      @(negedge clk);
      guard++;
    end while (!(pa && !a_lo) && guard < 4 * P);
  endtask

  task automatic measure(output int sh, output int ahi, output int bhi,
                         output int pos, output int neg, output int per);
    logic pa, pb;
    sh = -1; ahi = 0; bhi = 0; pos = 0; neg = 0;
    wait_start();
    pb = b_lo;
    pa = a_lo;
    for (int n = 0; n < P; n++) begin
      ahi += int'(a_hi);
      bhi += int'(b_hi);
      pos += int'(a_hi && b_lo);
      neg += int'(a_lo && b_hi);
      if (n > 0 && pb && !b_lo && sh < 0) sh = n;
      pb = b_lo;
      pa = a_lo;
      @(negedge clk);
    end
    per = (pa && !a_lo) ? P : 0;
  endtask

  task automatic apply(input int duty, input int mn, input int cs, input bit skp);
    duty_cmd = 6'(duty);
    min_on   = 6'(mn);
    cs_code  = 10'(cs);
    skip_req = skp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sh, ahi, bhi, pos, neg, per, sum;
    rst_n     = 1'b0;
    ilim      = 1'b0;
    band_thr  = {10'd600, 10'd400, 10'd200};
    band_hyst = 10'd20;
    dt_table  = {8'd8, 8'd6, 8'd4, 8'd2};
    apply(V_DUTY[0], V_MIN[0], V_CS[0], 1'b0);

    // R10: gates low in reset and through the first full period after release.
    repeat (5) @(negedge clk);
    check("R10 reset gates", int'({a_hi, a_lo, b_hi, b_lo}), 0);
    rst_n = 1'b1;
    sum = 0;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      sum += int'(a_hi) + int'(a_lo) + int'(b_hi) + int'(b_lo);
    end
    check("R10 first period dark", sum, 0);
    sum = 0;
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      sum += int'(a_hi) + int'(a_lo) + int'(b_hi) + int'(b_lo);
    end
    check("R10 drive after first period", int'(sum > 0), 1);

    // Vector table: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      apply(V_DUTY[v], V_MIN[v], V_CS[v], 1'b0);
      repeat (3 * P) @(negedge clk);
      measure(sh, ahi, bhi, pos, neg, per);
      check($sformatf("R1 period v%0d", v), per, P);
      check($sformatf("R2 R5 shift v%0d", v), sh, E_ON[v]);
      check($sformatf("R3 R4 a_hi width v%0d", v), ahi, HALF - E_DT[v]);
      check($sformatf("R3 R4 b_hi width v%0d", v), bhi, HALF - E_DT[v]);
      check($sformatf("R7 positive v%0d", v), pos, (E_ON[v] > E_DT[v]) ? E_ON[v] - E_DT[v] : 0);
      check($sformatf("R7 negative v%0d", v), neg, (E_ON[v] > E_DT[v]) ? E_ON[v] - E_DT[v] : 0);
    end

    // R6: skipped periods are fully dark.
    apply(3, 8, 100, 1'b1);
    repeat (2 * P) @(negedge clk);
    sum = 0;
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      sum += int'(a_hi) + int'(a_lo) + int'(b_hi) + int'(b_lo);
    end
    check("R6 skipped periods dark", sum, 0);

    // R6: skip request ignored when demand is at or above the floor.
    apply(10, 8, 100, 1'b1);
    repeat (3 * P) @(negedge clk);
    measure(sh, ahi, bhi, pos, neg, per);
    check("R6 skip ignored shift", sh, 10);
    check("R6 skip ignored a_hi", ahi, HALF - 2);

    // R9: a mid-period duty change waits for the next period.
    apply(20, 5, 100, 1'b0);
    repeat (3 * P) @(negedge clk);
    wait_start();
    repeat (5) @(negedge clk);
    duty_cmd = 6'd10;
    begin
      logic pb;
      int n;
      n = 5;
      sh = -1;
      pb = b_lo;
      while (n < P - 1) begin
        @(negedge clk);
        n++;
        if (pb && !b_lo && sh < 0) sh = n;
        pb = b_lo;
      end
    end
    check("R9 current period keeps old shift", sh, 20);
    measure(sh, ahi, bhi, pos, neg, per);
    check("R9 next period takes new shift", sh, 10);

    // R8: peak-current cut of the leading leg for the rest of the half.
    apply(20, 5, 100, 1'b0);
    repeat (3 * P) @(negedge clk);
    wait_start();
    repeat (15) @(negedge clk);
    check("R8 a_hi before cut", int'(a_hi), 1);
    ilim = 1'b1;
    @(negedge clk);
    ilim = 1'b0;
    check("R8 a_hi cut next edge", int'(a_hi), 0);
    sum = 0;
    for (int k = 17; k <= 31; k++) begin
      @(negedge clk);
      sum += int'(a_hi);
    end
    check("R8 a_hi stays low to half end", sum, 0);
    sum = 0;
    for (int k = 32; k <= 63; k++) begin
      @(negedge clk);
      sum += int'(a_lo);
    end
    check("R8 next half a_lo width", sum, HALF - 2);

    // R10: reset in the middle of a driven interval.
    wait_start();
    repeat (10) @(negedge clk);
    check("R10 a_hi high before reset", int'(a_hi), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 gates low after sync reset", int'({a_hi, a_lo, b_hi, b_lo}), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule